// File: doc/BRIEF.md
# Round-Robin Threshold Fault Monitor

This block scans a fixed set of monitored supply channels in strict rotation. A converter outside the block delivers one result, with a valid strobe, for whichever channel the block currently selects. Each result is stored in that channel's result register and tested against the channel's own high and low limits. A violation latches a sticky per-channel flag, as long as that channel has fault generation enabled and the boot mask is inactive.

The latched flags drive a set of general-purpose output pins through per-pin selection masks, so each pin can signal any chosen group of channels. A separate selection mask marks channels as critical. Any flagged critical channel raises a shutdown request. The first cycle of each such request also produces a single-cycle trigger that an external fault recorder can use.

Top module: `fmon_top`

## Requirements
- R1: `ch_sel_o` holds the index of the channel being converted, from 0 to NUM_CH-1. Index 0 is the first channel in the rotation.
- R2: After a clock edge at which `conv_valid_i` is high, `ch_sel_o` advances by one, and it wraps from NUM_CH-1 back to 0. At any other edge it keeps its value.
- R3: A result strobed at an edge is written to the slot of the channel selected at that edge, bits [k*RES_W +: RES_W] of `result_o`. It is visible in the next cycle, and the other slots do not change.
- R4: The high flag of channel k is set when the result is strictly greater than `ov_limit_i[k*RES_W +: RES_W]`. The low flag is set when the result is strictly less than `uv_limit_i[k*RES_W +: RES_W]`. A result equal to a limit sets no flag. Flags appear in the cycle after the strobe.
- R5: When `flt_en_i[k]` is low, a violation on channel k sets no flag, but the result is still stored.
- R6: While `boot_mask_i` is high, no strobed result sets any flag. Results are still stored and the selector still advances.
- R7: Flags stay set until `flt_clr_i[k]` is high at an edge, which clears both flags of channel k. A violation on channel k at that same edge takes priority and leaves its flag set.
- R8: `gpio_o[g]` equals the OR, over all channels k, of (`ov_flag_o[k]` | `uv_flag_o[k]`) AND `gpio_mask_i[g*NUM_CH+k]`. Both the flags and the mask are taken from the previous cycle.
- R9: `shdn_req_o` equals the OR of the channel faults ANDed with `shdn_mask_i`. It uses the same one-cycle lag as R8.
- R10: `log_trig_o` is high for exactly one cycle: the first cycle in which `shdn_req_o` is high after a cycle in which it was low.
- R11: While reset is active, and in the first cycle after it, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_valid_i | input | 1 | Conversion result valid strobe |
| conv_data_i | input | RES_W | Conversion result for the selected channel |
| boot_mask_i | input | 1 | Suppresses all fault setting while high |
| flt_en_i | input | NUM_CH | Per-channel fault generation enable |
| ov_limit_i | input | NUM_CH*RES_W | Per-channel high limits |
| uv_limit_i | input | NUM_CH*RES_W | Per-channel low limits |
| flt_clr_i | input | NUM_CH | Per-channel flag clear strobe |
| gpio_mask_i | input | NUM_GPIO*NUM_CH | Channel selection mask for each output pin |
| shdn_mask_i | input | NUM_CH | Channels treated as critical |
| ch_sel_o | output | CH_W | Channel currently selected for conversion |
| result_o | output | NUM_CH*RES_W | Stored results, one slot per channel |
| ov_flag_o | output | NUM_CH | Sticky high-limit flags |
| uv_flag_o | output | NUM_CH | Sticky low-limit flags |
| gpio_o | output | NUM_GPIO | Combined fault pins |
| shdn_req_o | output | 1 | Shutdown request |
| log_trig_o | output | 1 | One-cycle fault-record trigger |

## Verification
The assertions assume that the converter returns a result only for the channel shown on `ch_sel_o`. They also assume that the limits and masks are quasi-static, so that a value sampled one cycle earlier is the one the logic used. The bench changes limits, enables, masks and the boot mask only between conversions, a full clock period before the strobe edge. It also pulses the clear and valid inputs for a single cycle each, so every flag change can be traced to a single edge.

// File: rtl/fmon_pkg.sv
package fmon_pkg;

    // Outcome of testing one result against a channel's limit pair.
    typedef enum logic [1:0] {
        CMP_INSIDE = 2'b00,
        CMP_HIGH   = 2'b01,
        CMP_LOW    = 2'b10
    } cmp_verdict_t;

endpackage

// File: rtl/fmon_scan.sv
module fmon_scan #(
    parameter int NUM_CH = 6,
    parameter int CH_W   = $clog2(NUM_CH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    output logic [CH_W-1:0] sel_o
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    typedef struct packed {
        logic [CH_W-1:0] sel;
    } scan_s_t;

    scan_s_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            if (st_q.sel == LAST_CH) begin
                st_d.sel = '0;
            end else begin
                st_d.sel = st_q.sel + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

endmodule

// File: rtl/fmon_chan.sv
module fmon_chan
    import fmon_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic [RES_W-1:0] data_i,
    input  logic [RES_W-1:0] ov_lim_i,
    input  logic [RES_W-1:0] uv_lim_i,
    input  logic             en_i,
    input  logic             mask_i,
    input  logic             clr_i,
    output logic [RES_W-1:0] result_o,
    output logic             ov_o,
    output logic             uv_o
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             ov;
        logic             uv;
    } chan_s_t;

    chan_s_t      c_d, c_q;
    cmp_verdict_t verdict;
    logic         armed;

    // Limit test on the incoming result; the high test wins if limits overlap.
    always_comb begin
        if (data_i > ov_lim_i) begin
            verdict = CMP_HIGH;
        end else if (data_i < uv_lim_i) begin
            verdict = CMP_LOW;
        end else begin
            verdict = CMP_INSIDE;
        end
    end

    always_comb begin
        armed = hit_i & en_i & ~mask_i;
        c_d   = c_q;
        if (clr_i) begin
            c_d.ov = 1'b0;
            c_d.uv = 1'b0;
        end
        if (hit_i) begin
            c_d.res = data_i;
        end
        if (armed && verdict == CMP_HIGH) begin
            c_d.ov = 1'b1;
        end
        if (armed && verdict == CMP_LOW) begin
            c_d.uv = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign result_o = c_q.res;
    assign ov_o     = c_q.ov;
    assign uv_o     = c_q.uv;

endmodule

// File: rtl/fmon_combine.sv
module fmon_combine #(
    parameter int NUM_CH   = 6,
    parameter int NUM_GPIO = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          fault_i,
    input  logic [NUM_GPIO*NUM_CH-1:0] gpio_mask_i,
    input  logic [NUM_CH-1:0]          shdn_mask_i,
    output logic [NUM_GPIO-1:0]        gpio_o,
    output logic                       shdn_o,
    output logic                       log_o
);

    typedef struct packed {
        logic [NUM_GPIO-1:0] gpio;
        logic                shdn;
        logic                log;
    } comb_s_t;

    comb_s_t cb_d, cb_q;

    always_comb begin
        cb_d = cb_q;
        for (int g = 0; g < NUM_GPIO; g++) begin
            cb_d.gpio[g] = |(fault_i & gpio_mask_i[g*NUM_CH +: NUM_CH]);
        end
        cb_d.shdn = |(fault_i & shdn_mask_i);
        cb_d.log  = cb_d.shdn & ~cb_q.shdn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cb_q <= '0;
        end else begin
            cb_q <= cb_d;
        end
    end

    assign gpio_o = cb_q.gpio;
    assign shdn_o = cb_q.shdn;
    assign log_o  = cb_q.log;

endmodule

// File: rtl/fmon_top.sv
module fmon_top #(
    parameter int NUM_CH   = 6,
    parameter int RES_W    = 10,
    parameter int NUM_GPIO = 4,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       conv_valid_i,
    input  logic [RES_W-1:0]           conv_data_i,
    input  logic                       boot_mask_i,
    input  logic [NUM_CH-1:0]          flt_en_i,
    input  logic [NUM_CH*RES_W-1:0]    ov_limit_i,
    input  logic [NUM_CH*RES_W-1:0]    uv_limit_i,
    input  logic [NUM_CH-1:0]          flt_clr_i,
    input  logic [NUM_GPIO*NUM_CH-1:0] gpio_mask_i,
    input  logic [NUM_CH-1:0]          shdn_mask_i,
    output logic [CH_W-1:0]            ch_sel_o,
    output logic [NUM_CH*RES_W-1:0]    result_o,
    output logic [NUM_CH-1:0]          ov_flag_o,
    output logic [NUM_CH-1:0]          uv_flag_o,
    output logic [NUM_GPIO-1:0]        gpio_o,
    output logic                       shdn_req_o,
    output logic                       log_trig_o
);

    logic [CH_W-1:0]   sel;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] fault;

    fmon_scan #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_scan (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (conv_valid_i),
        .sel_o  (sel)
    );

    for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
        assign hit[k] = conv_valid_i && (sel == CH_W'(k));

        fmon_chan #(
            .RES_W (RES_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .hit_i    (hit[k]),
            .data_i   (conv_data_i),
            .ov_lim_i (ov_limit_i[k*RES_W +: RES_W]),
            .uv_lim_i (uv_limit_i[k*RES_W +: RES_W]),
            .en_i     (flt_en_i[k]),
            .mask_i   (boot_mask_i),
            .clr_i    (flt_clr_i[k]),
            .result_o (result_o[k*RES_W +: RES_W]),
            .ov_o     (ov_flag_o[k]),
            .uv_o     (uv_flag_o[k])
        );

        assign fault[k] = ov_flag_o[k] | uv_flag_o[k];
    end

    fmon_combine #(
        .NUM_CH   (NUM_CH),
        .NUM_GPIO (NUM_GPIO)
    ) u_comb (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_i     (fault),
        .gpio_mask_i (gpio_mask_i),
        .shdn_mask_i (shdn_mask_i),
        .gpio_o      (gpio_o),
        .shdn_o      (shdn_req_o),
        .log_o       (log_trig_o)
    );

    assign ch_sel_o = sel;

endmodule

// File: rtl/fmon_sva.sv
module fmon_sva #(
    parameter int NUM_CH   = 6,
    parameter int RES_W    = 10,
    parameter int NUM_GPIO = 4,
    parameter int CH_W     = $clog2(NUM_CH)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       conv_valid_i,
    input logic [RES_W-1:0]           conv_data_i,
    input logic                       boot_mask_i,
    input logic [NUM_CH-1:0]          flt_en_i,
    input logic [NUM_CH*RES_W-1:0]    ov_limit_i,
    input logic [NUM_CH*RES_W-1:0]    uv_limit_i,
    input logic [NUM_CH-1:0]          flt_clr_i,
    input logic [NUM_GPIO*NUM_CH-1:0] gpio_mask_i,
    input logic [NUM_CH-1:0]          shdn_mask_i,
    input logic [CH_W-1:0]            ch_sel_o,
    input logic [NUM_CH*RES_W-1:0]    result_o,
    input logic [NUM_CH-1:0]          ov_flag_o,
    input logic [NUM_CH-1:0]          uv_flag_o,
    input logic [NUM_GPIO-1:0]        gpio_o,
    input logic                       shdn_req_o,
    input logic                       log_trig_o
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    logic [NUM_CH-1:0] fault;
    assign fault = ov_flag_o | uv_flag_o;

    // Record of the previous strobe, used for the storage check (R3).
    logic             prev_vld;
    logic [CH_W-1:0]  prev_sel;
    logic [RES_W-1:0] prev_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_vld  <= 1'b0;
            prev_sel  <= '0;
            prev_data <= '0;
        end else begin
            prev_vld  <= conv_valid_i;
            prev_sel  <= ch_sel_o;
            prev_data <= conv_data_i;
        end
    end

    a_r1_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
        ch_sel_o <= LAST_CH);

    a_r2_sel_advance: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid_i |=> ch_sel_o == (($past(ch_sel_o) == LAST_CH) ? '0 : $past(ch_sel_o) + 1'b1));

    a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_valid_i |=> $stable(ch_sel_o));

    a_r3_stored: assert property (@(posedge clk) disable iff (!rst_n)
        prev_vld |-> result_o[prev_sel*RES_W +: RES_W] == prev_data);

    a_r6_boot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        boot_mask_i |=> (fault & ~$past(fault)) == '0);

    a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fault & ~$past(fault) & ~$past(flt_en_i)) == '0);

    a_r9_shdn: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> shdn_req_o == |($past(fault) & $past(shdn_mask_i)));

    a_r10_log_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> log_trig_o == (shdn_req_o && !$past(shdn_req_o)));

    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($past(ov_flag_o | uv_flag_o) & ~$past(flt_clr_i) & ~fault) == '0);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        localparam logic [CH_W-1:0] KSEL = CH_W'(k);

        a_r4_ov_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ov_flag_o[k]) |-> $past(conv_valid_i) && $past(ch_sel_o) == KSEL
                && $past(conv_data_i) > $past(ov_limit_i[k*RES_W +: RES_W]));

        a_r4_uv_cause: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(uv_flag_o[k]) |-> $past(conv_valid_i) && $past(ch_sel_o) == KSEL
                && $past(conv_data_i) < $past(uv_limit_i[k*RES_W +: RES_W]));
    end

    for (genvar g = 0; g < NUM_GPIO; g++) begin : g_pin
        a_r8_gpio: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> gpio_o[g] == |($past(fault) & $past(gpio_mask_i[g*NUM_CH +: NUM_CH])));
    end

endmodule

bind fmon_top fmon_sva #(
    .NUM_CH   (NUM_CH),
    .RES_W    (RES_W),
    .NUM_GPIO (NUM_GPIO),
    .CH_W     (CH_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .conv_valid_i (conv_valid_i),
    .conv_data_i  (conv_data_i),
    .boot_mask_i  (boot_mask_i),
    .flt_en_i     (flt_en_i),
    .ov_limit_i   (ov_limit_i),
    .uv_limit_i   (uv_limit_i),
    .flt_clr_i    (flt_clr_i),
    .gpio_mask_i  (gpio_mask_i),
    .shdn_mask_i  (shdn_mask_i),
    .ch_sel_o     (ch_sel_o),
    .result_o     (result_o),
    .ov_flag_o    (ov_flag_o),
    .uv_flag_o    (uv_flag_o),
    .gpio_o       (gpio_o),
    .shdn_req_o   (shdn_req_o),
    .log_trig_o   (log_trig_o)
);

// File: tb/fmon_top_test.sv
module fmon_top_test;

    localparam int NUM_CH   = 6;
    localparam int RES_W    = 10;
    localparam int NUM_GPIO = 4;
    localparam int CH_W     = $clog2(NUM_CH);

    logic                       clk = 1'b0;
    logic                       rst_n = 1'b0;
    logic                       conv_valid_i = 1'b0;
    logic [RES_W-1:0]           conv_data_i = '0;
    logic                       boot_mask_i = 1'b0;
    logic [NUM_CH-1:0]          flt_en_i = '1;
    logic [NUM_CH*RES_W-1:0]    ov_limit_i;
    logic [NUM_CH*RES_W-1:0]    uv_limit_i;
    logic [NUM_CH-1:0]          flt_clr_i = '0;
    logic [NUM_GPIO*NUM_CH-1:0] gpio_mask_i;
    logic [NUM_CH-1:0]          shdn_mask_i;
    logic [CH_W-1:0]            ch_sel_o;
    logic [NUM_CH*RES_W-1:0]    result_o;
    logic [NUM_CH-1:0]          ov_flag_o;
    logic [NUM_CH-1:0]          uv_flag_o;
    logic [NUM_GPIO-1:0]        gpio_o;
    logic                       shdn_req_o;
    logic                       log_trig_o;

    always #2 clk = ~clk;  // 250 MHz

    fmon_top #(
        .NUM_CH   (NUM_CH),
        .RES_W    (RES_W),
        .NUM_GPIO (NUM_GPIO)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .conv_valid_i (conv_valid_i),
        .conv_data_i  (conv_data_i),
        .boot_mask_i  (boot_mask_i),
        .flt_en_i     (flt_en_i),
        .ov_limit_i   (ov_limit_i),
        .uv_limit_i   (uv_limit_i),
        .flt_clr_i    (flt_clr_i),
        .gpio_mask_i  (gpio_mask_i),
        .shdn_mask_i  (shdn_mask_i),
        .ch_sel_o     (ch_sel_o),
        .result_o     (result_o),
        .ov_flag_o    (ov_flag_o),
        .uv_flag_o    (uv_flag_o),
        .gpio_o       (gpio_o),
        .shdn_req_o   (shdn_req_o),
        .log_trig_o   (log_trig_o)
    );

    typedef struct {
        logic [CH_W-1:0]         sel;
        logic [NUM_CH*RES_W-1:0] res;
        logic [NUM_CH-1:0]       ov;
        logic [NUM_CH-1:0]       uv;
        logic [NUM_GPIO-1:0]     gpio;
        logic                    shdn;
        logic                    log;
        string                   tag;
    } exp_t;

    exp_t q[$];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Reference model state.
    int                      m_sel  = 0;
    logic [NUM_CH*RES_W-1:0] m_res  = '0;
    logic [NUM_CH-1:0]       m_ov   = '0;
    logic [NUM_CH-1:0]       m_uv   = '0;
    logic                    m_shdn = 1'b0;

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and predicts the post-edge outputs.
    task automatic step(input logic v, input logic [RES_W-1:0] d, input logic [NUM_CH-1:0] clr, input string tag);
        exp_t              e;
        logic [NUM_CH-1:0] flt_old;
        @(negedge clk);
        conv_valid_i = v;
        conv_data_i  = d;
        flt_clr_i    = clr;
        flt_old = m_ov | m_uv;
        for (int g = 0; g < NUM_GPIO; g++) begin
            e.gpio[g] = 1'b0;
            for (int k = 0; k < NUM_CH; k++) begin
                if (flt_old[k] && gpio_mask_i[g*NUM_CH+k]) e.gpio[g] = 1'b1;
            end
        end
        e.shdn = |(flt_old & shdn_mask_i);
        e.log  = e.shdn && !m_shdn;
        m_shdn = e.shdn;
        m_ov = m_ov & ~clr;
        m_uv = m_uv & ~clr;
        if (v) begin
            m_res[m_sel*RES_W +: RES_W] = d;
            if (flt_en_i[m_sel] && !boot_mask_i) begin
                if (d > ov_limit_i[m_sel*RES_W +: RES_W]) m_ov[m_sel] = 1'b1;
                else if (d < uv_limit_i[m_sel*RES_W +: RES_W]) m_uv[m_sel] = 1'b1;
            end
            m_sel = (m_sel + 1) % NUM_CH;
        end
        e.sel = CH_W'(m_sel);
        e.res = m_res;
        e.ov  = m_ov;
        e.uv  = m_uv;
        e.tag = tag;
        @(posedge clk);
        #1;
        conv_valid_i = 1'b0;
        flt_clr_i    = '0;
        q.push_back(e);
    endtask

    // Monitor: compares the outputs after each edge with the queued prediction.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, "sel",  64'(ch_sel_o),   64'(e.sel));
                check(e.tag, "res",  64'(result_o),   64'(e.res));
                check(e.tag, "ov",   64'(ov_flag_o),  64'(e.ov));
                check(e.tag, "uv",   64'(uv_flag_o),  64'(e.uv));
                check(e.tag, "gpio", 64'(gpio_o),     64'(e.gpio));
                check(e.tag, "shdn", 64'(shdn_req_o), 64'(e.shdn));
                check(e.tag, "log",  64'(log_trig_o), 64'(e.log));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NUM_CH; k++) begin
            ov_limit_i[k*RES_W +: RES_W] = RES_W'(800 + 10 * k);
            uv_limit_i[k*RES_W +: RES_W] = RES_W'(100 + 10 * k);
        end
        gpio_mask_i = '0;
        gpio_mask_i[0*NUM_CH +: NUM_CH] = 6'b000001;
        gpio_mask_i[1*NUM_CH +: NUM_CH] = 6'b000110;
        gpio_mask_i[2*NUM_CH +: NUM_CH] = 6'b111111;
        gpio_mask_i[3*NUM_CH +: NUM_CH] = 6'b000000;
        shdn_mask_i = 6'b110000;

        // R11: outputs are zero during reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11", "sel",  64'(ch_sel_o), 0);
        check("R11", "res",  64'(result_o), 0);
        check("R11", "flags", 64'({ov_flag_o, uv_flag_o}), 0);
        check("R11", "outs", 64'({gpio_o, shdn_req_o, log_trig_o}), 0);
        rst_n = 1'b1;

        // R1 R2 R3: in-range results on every channel, wrap back to 0.
        for (int k = 0; k < NUM_CH; k++) step(1'b1, RES_W'(500 + k), '0, "R3");
        step(1'b0, 10'd999, '0, "R2");  // idle: selector holds, nothing stored

        // R4: equality at both limits sets nothing; one beyond does.
        step(1'b1, 10'd800, '0, "R4");  // ch0 == high limit
        step(1'b1, 10'd110, '0, "R4");  // ch1 == low limit
        step(1'b1, 10'd821, '0, "R4");  // ch2 above high limit
        step(1'b1, 10'd129, '0, "R4");  // ch3 below low limit
        step(1'b1, 10'd500, '0, "R8");
        step(1'b1, 10'd500, '0, "R8");

        // R7: clear of ch2, then set wins over a same-edge clear on ch0.
        step(1'b0, 10'd0, 6'b000100, "R7");
        step(1'b1, 10'd900, 6'b000001, "R7");

        // R5: ch1 disabled, violation ignored but stored.
        flt_en_i = 6'b111101;
        step(1'b1, 10'd1000, '0, "R5");
        step(1'b1, 10'd500, '0, "R5");
        flt_en_i = '1;

        // R6: boot mask suppresses faults on ch3..ch5.
        boot_mask_i = 1'b1;
        step(1'b1, 10'd0, '0, "R6");
        step(1'b1, 10'd1023, '0, "R6");
        step(1'b1, 10'd0, '0, "R6");
        boot_mask_i = 1'b0;

        // R9 R10: critical fault on ch4, then another on ch5.
        for (int k = 0; k < 4; k++) step(1'b1, 10'd500, '0, "R9");
        step(1'b1, 10'd1023, '0, "R9");
        step(1'b1, 10'd5, '0, "R10");
        step(1'b0, 10'd0, '0, "R10");
        step(1'b0, 10'd0, '0, "R10");

        // R7 R9: clear everything, shutdown drops, then rises again.
        step(1'b0, 10'd0, '1, "R7");
        step(1'b0, 10'd0, '0, "R9");
        step(1'b0, 10'd0, '0, "R9");
        for (int k = 0; k < 4; k++) step(1'b1, 10'd500, '0, "R10");
        step(1'b1, 10'd900, '0, "R10");
        step(1'b0, 10'd0, '0, "R10");
        step(1'b0, 10'd0, '0, "R10");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule